// File: doc/BRIEF.md
# Dual-Style Host Bus Interface

This block sits between an external processor bus and the small internal register file of a peripheral controller. It takes a three-bit register address either from dedicated address pins or, in multiplexed mode, from the low lines of the shared address/data bus, where an address-latch strobe captures it. Two processor strobe conventions are supported and chosen by a static input. One uses separate active-low read and write strobes. The other uses a direction line with an active-low data strobe.

All asynchronous strobes are resynchronised into the block clock. Every write produces one single-cycle write request to the register file when the strobe ends. Read data is driven onto the bus only while a read is qualified. A word-mode control bit lets the data register at address 7 be accessed as a 16-bit word. In that case the upper byte lane is driven, an active-low 16-bit indicator is asserted, and an optional byte swapper exchanges the two bytes.

A timing-select pin requests fast bus timing. The request is honoured only when the bus is not multiplexed.

Top module: `hostbus_if`

## Requirements
- R1: With `cfg_mux_n` high, the register address presented on `rf_addr` is taken from `addr_in`, with bit 0 as the least significant bit.
- R2: With `cfg_mux_n` low, the address is taken from `dlo_in[2:0]` and captured while `ale` is high. In this mode `addr_in` has no effect on `rf_addr`, and `dlo_in[7:3]` carry data only.
- R3: With `cfg_style` = 0, `wr_dir` is an active-low write strobe and `rd_ds` is an active-low read strobe.
- R4: With `cfg_style` = 1, `rd_ds` is an active-low data strobe. `wr_dir` low marks a write and high marks a read.
- R5: Each qualified write strobe gives exactly one `rf_wr` pulse, one clock wide, after the strobe ends. A strobe with `cs_n` high gives no pulse. Address and data must be held until that pulse.
- R6: `dlo_oe` is high only while `cs_n` and the read qualifier are both active, after synchronisation. Otherwise it is low and `dlo_out` is 0.
- R7: `dhi_oe` is high only during a read of address 7 with `ctl_word_en` = 1. With `ctl_word_en` = 0 it never goes high.
- R8: `iocs16_n` is low only while the chip is selected, the address is 7 and `ctl_word_en` = 1. At all other times it is driven high.
- R9: A word access (address 7 with `ctl_word_en` = 1) writes `{dhi_in, dlo_in}` to `rf_wdata`. With `ctl_swap_en` = 1 the two bytes are exchanged on writes and on reads. A byte access writes `{8'h00, dlo_in}` and reads `rf_rdata[7:0]` with no swap.
- R10: `fast_tmg` is high only when `cfg_tmg_n` is low and `cfg_mux_n` is high.
- R11: After reset, `rf_wr`, `rf_rd`, `dlo_oe` and `dhi_oe` are low and `iocs16_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mux_n | input | 1 | Low selects the multiplexed address/data bus |
| cfg_style | input | 1 | Strobe convention: 0 separate strobes, 1 direction plus data strobe |
| cfg_tmg_n | input | 1 | Low requests fast bus timing |
| ctl_word_en | input | 1 | Enables 16-bit access to the data register |
| ctl_swap_en | input | 1 | Exchanges the bytes on word accesses |
| cs_n | input | 1 | Chip select, active low |
| addr_in | input | 3 | Dedicated address pins |
| ale | input | 1 | Address-latch strobe, multiplexed mode |
| wr_dir | input | 1 | Write strobe or direction line |
| rd_ds | input | 1 | Read strobe or data strobe |
| dlo_in | input | 8 | Low bus byte in (also carries address in multiplexed mode) |
| dhi_in | input | 8 | High bus byte in |
| dlo_out | output | 8 | Low bus byte out |
| dlo_oe | output | 1 | Low byte output enable |
| dhi_out | output | 8 | High bus byte out |
| dhi_oe | output | 1 | High byte output enable |
| iocs16_n | output | 1 | 16-bit access indicator, active low, push-pull |
| fast_tmg | output | 1 | Fast timing granted |
| rf_wr | output | 1 | Register file write pulse |
| rf_rd | output | 1 | Register file read qualifier |
| rf_addr | output | 3 | Register file address |
| rf_wdata | output | 16 | Register file write data |
| rf_rdata | input | 16 | Register file read data |

## Verification
Suppose the captured address or the address latch holds a wrong value. The fault shows up on `rf_addr` and in the returned read data, within two or three clocks of the strobe being synchronised. A stale write-edge register shows up as a missing or doubled `rf_wr` pulse in the clock after the strobe ends. A wrong word-mode qualification shows up as `dhi_oe` or `iocs16_n` toggling on a byte-register access, or as bytes left unswapped. The bench samples all of these at fixed offsets after each strobe edge, in both address modes and both strobe conventions.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
   typedef enum logic {
      STY_SPLIT = 1'b0,
      STY_DIRDS = 1'b1
   } strobe_style_e;

   typedef struct packed {
      logic ale;
      logic rd;
      logic wr;
      logic sel;
   } bus_ctl_t;

   localparam int CTL_W = $bits(bus_ctl_t);
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hbi_strobe_decode.sv
module hbi_strobe_decode
   import hbi_pkg::*;
(
   input  logic cfg_style,
   input  logic cfg_mux_n,
   input  logic cs_n,
   input  logic wr_dir,
   input  logic rd_ds,
   input  logic ale,
   output bus_ctl_t ctl
);
   strobe_style_e style;
   logic wr_raw, rd_raw;

   assign style = strobe_style_e'(cfg_style);

   always_comb begin
      unique case (style)
         STY_SPLIT: begin
            wr_raw = ~wr_dir;
            rd_raw = ~rd_ds;
         end
         STY_DIRDS: begin
            wr_raw = ~rd_ds & ~wr_dir;
            rd_raw = ~rd_ds &  wr_dir;
         end
         default: begin
            wr_raw = 1'b0;
            rd_raw = 1'b0;
         end
      endcase
   end

   always_comb begin
      ctl.sel = ~cs_n;
      ctl.wr  = ~cs_n & wr_raw;
      ctl.rd  = ~cs_n & rd_raw;
      ctl.ale = ~cfg_mux_n & ale;
   end
endmodule

// File: rtl/hbi_addr_path.sv
module hbi_addr_path #(
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_mux_n,
   input  logic          ale_s,
   input  logic          sel_s,
   input  logic [AW-1:0] addr_in,
   input  logic [AW-1:0] ad_lo,
   output logic [AW-1:0] cap_addr
);
   logic [AW-1:0] alat;
   logic [AW-1:0] addr_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     alat <= '0;
      else if (ale_s) alat <= ad_lo;
   end

   assign addr_eff = cfg_mux_n ? addr_in : alat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cap_addr <= '0;
      else if (sel_s) cap_addr <= addr_eff;
   end
endmodule

// File: rtl/hbi_data_path.sv
module hbi_data_path #(
   parameter int AW        = 3,
   parameter int BW        = 8,
   parameter int DATA_ADDR = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_s,
   input  logic            rd_s,
   input  logic            word_en,
   input  logic            swap_en,
   input  logic [AW-1:0]   cap_addr,
   input  logic [BW-1:0]   dlo_in,
   input  logic [BW-1:0]   dhi_in,
   input  logic [2*BW-1:0] rf_rdata,
   output logic [2*BW-1:0] rf_wdata,
   output logic [BW-1:0]   dlo_out,
   output logic            dlo_oe,
   output logic [BW-1:0]   dhi_out,
   output logic            dhi_oe,
   output logic            word_acc
);
   localparam logic [AW-1:0] DSEL = AW'(DATA_ADDR);

   logic [BW-1:0] cap_lo, cap_hi;
   logic [BW-1:0] rd_lo,  rd_hi;

   assign word_acc = word_en & (cap_addr == DSEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_lo <= '0;
         cap_hi <= '0;
      end else if (wr_s) begin
         cap_lo <= dlo_in;
         cap_hi <= dhi_in;
      end
   end

   assign rd_lo = rf_rdata[BW-1:0];
   assign rd_hi = rf_rdata[2*BW-1:BW];

   always_comb begin
      if (!word_acc)    rf_wdata = {{BW{1'b0}}, cap_lo};
      else if (swap_en) rf_wdata = {cap_lo, cap_hi};
      else              rf_wdata = {cap_hi, cap_lo};
   end

   always_comb begin
      dlo_oe  = rd_s;
      dhi_oe  = rd_s & word_acc;
      dlo_out = '0;
      dhi_out = '0;
      if (rd_s) begin
         dlo_out = (word_acc && swap_en) ? rd_hi : rd_lo;
         if (word_acc) dhi_out = swap_en ? rd_lo : rd_hi;
      end
   end
endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
   import hbi_pkg::*;
#(
   parameter int AW          = 3,
   parameter int BW          = 8,
   parameter int DATA_ADDR   = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_mux_n,
   input  logic            cfg_style,
   input  logic            cfg_tmg_n,
   input  logic            ctl_word_en,
   input  logic            ctl_swap_en,
   input  logic            cs_n,
   input  logic [AW-1:0]   addr_in,
   input  logic            ale,
   input  logic            wr_dir,
   input  logic            rd_ds,
   input  logic [BW-1:0]   dlo_in,
   input  logic [BW-1:0]   dhi_in,
   output logic [BW-1:0]   dlo_out,
   output logic            dlo_oe,
   output logic [BW-1:0]   dhi_out,
   output logic            dhi_oe,
   output logic            iocs16_n,
   output logic            fast_tmg,
   output logic            rf_wr,
   output logic            rf_rd,
   output logic [AW-1:0]   rf_addr,
   output logic [2*BW-1:0] rf_wdata,
   input  logic [2*BW-1:0] rf_rdata
);
   if (AW < 1 || AW > BW) begin : g_bad_aw
      $error("hostbus_if: AW must lie in 1..BW");
   end
   if (DATA_ADDR < 0 || DATA_ADDR >= (1 << AW)) begin : g_bad_daddr
      $error("hostbus_if: DATA_ADDR outside address map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hostbus_if: SYNC_STAGES must be at least 2");
   end

   bus_ctl_t ctl_raw, ctl_s;
   logic     wr_d;
   logic     word_acc;
   logic [AW-1:0] cap_addr;

   hbi_strobe_decode u_dec (
      .cfg_style (cfg_style),
      .cfg_mux_n (cfg_mux_n),
      .cs_n      (cs_n),
      .wr_dir    (wr_dir),
      .rd_ds     (rd_ds),
      .ale       (ale),
      .ctl       (ctl_raw)
   );

   hbi_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_s)
   );

   hbi_addr_path #(.AW(AW)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_mux_n (cfg_mux_n),
      .ale_s     (ctl_s.ale),
      .sel_s     (ctl_s.sel),
      .addr_in   (addr_in),
      .ad_lo     (dlo_in[AW-1:0]),
      .cap_addr  (cap_addr)
   );

   hbi_data_path #(.AW(AW), .BW(BW), .DATA_ADDR(DATA_ADDR)) u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_s     (ctl_s.wr),
      .rd_s     (ctl_s.rd),
      .word_en  (ctl_word_en),
      .swap_en  (ctl_swap_en),
      .cap_addr (cap_addr),
      .dlo_in   (dlo_in),
      .dhi_in   (dhi_in),
      .rf_rdata (rf_rdata),
      .rf_wdata (rf_wdata),
      .dlo_out  (dlo_out),
      .dlo_oe   (dlo_oe),
      .dhi_out  (dhi_out),
      .dhi_oe   (dhi_oe),
      .word_acc (word_acc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_d <= 1'b0;
      else        wr_d <= ctl_s.wr;
   end

   assign rf_wr    = wr_d & ~ctl_s.wr;
   assign rf_rd    = ctl_s.rd;
   assign rf_addr  = cap_addr;
   assign iocs16_n = ~(ctl_s.sel & word_acc);
   assign fast_tmg = ~cfg_tmg_n & cfg_mux_n;
endmodule

// File: rtl/hostbus_if_chk.sv
module hostbus_if_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_mux_n,
   input logic ctl_word_en,
   input logic dlo_oe,
   input logic dhi_oe,
   input logic fast_tmg,
   input logic rf_wr
);
   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr |=> !rf_wr);                                  // R5
   AST_NO_DRIVE_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr |-> !dlo_oe);                                 // R6
   AST_HI_OFF_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_word_en |-> !dhi_oe);                          // R7
   AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      dhi_oe |-> dlo_oe);                                 // R7
   AST_FAST_DEMUX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      fast_tmg |-> cfg_mux_n);                            // R10
endmodule

bind hostbus_if hostbus_if_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_mux_n   (cfg_mux_n),
   .ctl_word_en (ctl_word_en),
   .dlo_oe      (dlo_oe),
   .dhi_oe      (dhi_oe),
   .fast_tmg    (fast_tmg),
   .rf_wr       (rf_wr)
);

// File: tb/hostbus_if_tb.sv
`timescale 1ns/1ps
module hostbus_if_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_mux_n = 1'b1, cfg_style = 1'b0, cfg_tmg_n = 1'b1;
   logic        ctl_word_en = 1'b0, ctl_swap_en = 1'b0;
   logic        cs_n = 1'b1, ale = 1'b0, wr_dir = 1'b1, rd_ds = 1'b1;
   logic [2:0]  addr_in = '0;
   logic [7:0]  dlo_in = '0, dhi_in = '0;
   logic [7:0]  dlo_out, dhi_out;
   logic        dlo_oe, dhi_oe, iocs16_n, fast_tmg, rf_wr, rf_rd;
   logic [2:0]  rf_addr;
   logic [15:0] rf_wdata, rf_rdata;

   int total = 0, bad = 0, pulses = 0;
   logic [2:0]  last_addr = '0;
   logic [15:0] last_data = '0;

   always #2.5 clk = ~clk;

   hostbus_if u_dut (.*);

   function automatic logic [15:0] rd_model(input logic [2:0] a);
      return {a, 5'h15, a ^ 3'h5, 5'h0A};
   endfunction
   assign rf_rdata = rd_model(rf_addr);

   function automatic logic [15:0] exp_wdata(input logic [15:0] d, input bit word, input bit swp);
      if (!word) return {8'h00, d[7:0]};
      return swp ? {d[7:0], d[15:8]} : d;
   endfunction

   always @(negedge clk) if (rf_wr) begin
      pulses++;
      last_addr = rf_addr;
      last_data = rf_wdata;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input bit is_wr, input bit mux, input bit sty, input logic [2:0] a,
                       input logic [15:0] d, input bit we, input bit swp, input bit sel);
      int p0;
      bit word;
      logic [15:0] rd;
      string areq, sreq;
      areq = mux ? "R2" : "R1";
      sreq = sty ? "R4" : "R3";
      word = we && (a == 3'd7);
      cyc(1);
      cfg_mux_n = ~mux; cfg_style = sty; ctl_word_en = we; ctl_swap_en = swp;
      wr_dir = 1'b1; rd_ds = 1'b1;
      cyc(3);
      if (mux) begin
         dlo_in = {5'h1F, a}; ale = 1'b1; cs_n = ~sel;
         cyc(3);
         ale = 1'b0;
         cyc(3);
         addr_in = 3'($urandom);
      end else begin
         addr_in = a; cs_n = ~sel;
         cyc(3);
      end
      dlo_in = d[7:0]; dhi_in = d[15:8];
      p0 = pulses;
      if (sty) begin wr_dir = ~is_wr; rd_ds = 1'b0; end
      else if (is_wr) wr_dir = 1'b0;
      else rd_ds = 1'b0;
      cyc(5);
      if (!is_wr) begin
         rd = rd_model(a);
         if (sel) begin
            chk(rf_addr == a, areq, 32'(rf_addr), 32'(a));
            chk(dlo_oe && rf_rd, {sreq, " R6 read enable"}, 32'(dlo_oe), 1);
            chk(dlo_out == ((word && swp) ? rd[15:8] : rd[7:0]), "R9 low read byte",
                32'(dlo_out), 32'((word && swp) ? rd[15:8] : rd[7:0]));
            chk(dhi_oe == word, "R7 high lane enable", 32'(dhi_oe), 32'(word));
            if (word) chk(dhi_out == (swp ? rd[7:0] : rd[15:8]), "R9 high read byte",
                          32'(dhi_out), 32'(swp ? rd[7:0] : rd[15:8]));
            chk(iocs16_n == !word, "R8 indicator", 32'(iocs16_n), 32'(!word));
         end else begin
            chk(!dlo_oe && !dhi_oe, "R6 unselected read", 32'({dlo_oe, dhi_oe}), 0);
            chk(iocs16_n, "R8 unselected", 32'(iocs16_n), 1);
         end
      end
      wr_dir = 1'b1; rd_ds = 1'b1;
      cyc(5);
      cs_n = 1'b1;
      cyc(4);
      if (is_wr && sel) begin
         chk(pulses == p0 + 1, {sreq, " R5 one pulse"}, 32'(pulses - p0), 1);
         chk(last_addr == a, areq, 32'(last_addr), 32'(a));
         chk(last_data == exp_wdata(d, word, swp), "R9 write data",
             32'(last_data), 32'(exp_wdata(d, word, swp)));
      end else begin
         chk(pulses == p0, "R5 no pulse", 32'(pulses - p0), 0);
      end
      chk(!dlo_oe && !dhi_oe, "R6 released", 32'({dlo_oe, dhi_oe}), 0);
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2024);
      cyc(3);
      // R11 reset state
      chk(!rf_wr && !rf_rd && !dlo_oe && !dhi_oe, "R11 idle outputs",
          32'({rf_wr, rf_rd, dlo_oe, dhi_oe}), 0);
      chk(iocs16_n, "R11 indicator", 32'(iocs16_n), 1);
      rst_n = 1'b1;
      cyc(2);
      // R10 timing grant
      for (int k = 0; k < 4; k++) begin
         cfg_mux_n = k[0]; cfg_tmg_n = k[1];
         #1;
         chk(fast_tmg == (k[0] && !k[1]), "R10 fast timing", 32'(fast_tmg), 32'(k[0] && !k[1]));
      end
      // directed corners
      xfer(1, 0, 0, 3'd7, 16'hA55A, 1, 1, 1);
      xfer(0, 0, 0, 3'd7, 16'h0000, 1, 1, 1);
      xfer(1, 1, 1, 3'd7, 16'h1234, 1, 0, 1);
      xfer(0, 1, 1, 3'd7, 16'h0000, 1, 0, 1);
      xfer(1, 0, 1, 3'd7, 16'hBEEF, 0, 1, 1);
      xfer(0, 0, 0, 3'd7, 16'h0000, 0, 1, 1);
      xfer(0, 1, 0, 3'd3, 16'h0000, 1, 1, 1);
      xfer(1, 0, 0, 3'd2, 16'hC3C3, 1, 0, 0);
      xfer(0, 1, 1, 3'd5, 16'h0000, 1, 0, 0);
      for (int i = 0; i < 60; i++) begin
         logic [31:0] r;
         r = $urandom;
         xfer(r[0], r[1], r[2], r[5:3], 16'($urandom), r[6] | r[7], r[8], r[9] | r[10] | r[11]);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule